// File: doc/BRIEF.md
# Write Mirroring Address Policy

This unit sits beside a fast processor that keeps its own copy of memory. For every processor write it decides, in the same cycle, whether the write must also be copied out to the slower host memory so that the host's video and screen data stay coherent. The choice comes from an 8-bit mode byte that names a mirrored address region, the host bank that owns the mode, and whether the zero-page and stack area is always copied.

The mode byte can be loaded whole, or changed through four shortcut locations and a two-bit flag register, all in a register page at `$D0xx`. The flag register is derived from the mode byte, so the two never disagree. Register updates need the register-enable input; reads of the mode byte and the flag register are always available on `rdata_o`. Writes into the I/O area are always mirrored while I/O is mapped in.

Top module: `wm_mirror_policy`

## Requirements
- R1: `mirror_o` is 0 whenever `wr_i` is 0, and it reflects the write presented in the same cycle, using the mode held before that write's clock edge.
- R2: After reset the mode byte reads `8'hC1` at address `$D0B3` and the flag register reads `8'hC0` at `$D0B4`.
- R3: With region select S = {mode[7:6], mode[2]}: S=000 mirrors `$8000-$BFFF`, S=001 mirrors `$0000-$3FFF`, S=010 mirrors `$4000-$7FFF`, S=011 mirrors `$C000-$FFFF`.
- R4: S=100 mirrors only `$0400-$07FF`; S=101 mirrors nothing outside the I/O rule, and the zero-page override (R7) is ignored in that setting.
- R5: S=110 mirrors every address in either host bank; S=111 mirrors every address but only in the bank named by mode[1].
- R6: When `bank_i` differs from mode[1] and S is not 110, neither the region nor the zero-page override produces a mirror.
- R7: mode[0]=0 forces mirroring of `$0000-$01FF` in the owning bank; mode[0]=1 removes that forcing.
- R8: A write to `$D000-$DFFF` while `io_mapped_i` is 1 is always mirrored, whatever the mode and bank.
- R9: A write to `$D0B3` loads the mode byte only while `reg_en_i` is 1; otherwise the byte is unchanged.
- R10: While `reg_en_i` is 1, a write (any data) to `$D074`, `$D075`, `$D076`, `$D077` sets mode[7:6] to 00, 01, 10, 11 respectively and clears mode[2]; `$D077` also clears mode[1]; other bits are kept. With `reg_en_i` 0 these writes have no effect.
- R11: The flag register reads {code, 6'b0} with code 00 for S=000, 01 for S=010, 10 for S=100 and 11 otherwise; a write to `$D0B4` with `reg_en_i` 1 applies the shortcut of code data[7:6] as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Processor write strobe |
| addr_i | input | 16 | Processor address |
| data_i | input | 8 | Write data |
| bank_i | input | 1 | Host bank of the access |
| io_mapped_i | input | 1 | I/O area mapped in |
| reg_en_i | input | 1 | Register page writable |
| mirror_o | output | 1 | Copy this write to host memory |
| rdata_o | output | 8 | Mode byte or flag register read data |

## Verification
The checker watches on every cycle that idle cycles never mirror, that I/O writes always mirror, that a write from a non-owning bank is dropped outside mirror-all, that locked register writes leave the mode untouched, and that shortcut and flag writes land in the mode byte on the next cycle. The exact region boundaries of each mode, the zero-page override, the reset value and the read-back encodings depend on particular mode and address pairs, so only the bench's directed sequence, which walks every region select through both banks, shows them.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [2:0] {
    RG_HI8  = 3'b000,
    RG_LO0  = 3'b001,
    RG_LO4  = 3'b010,
    RG_TOP  = 3'b011,
    RG_SCR  = 3'b100,
    RG_NONE = 3'b101,
    RG_ALL  = 3'b110,
    RG_BANK = 3'b111
  } region_e;

  function automatic region_e region_of(input logic [7:0] m);
    return region_e'({m[7:6], m[2]});
  endfunction

  // shortcut code applied to a mode byte
  function automatic logic [7:0] apply_code(input logic [7:0] m, input logic [1:0] c);
    logic [7:0] r;
    r = m;
    r[7:6] = c;
    r[2] = 1'b0;
    if (c == 2'b11) r[1] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/wm_mode_reg.sv
module wm_mode_reg #(
  parameter logic [7:0] MODE_RST = 8'hC1,
  parameter logic [7:0] OFF_MODE = 8'hB3,
  parameter logic [7:0] OFF_FLAG = 8'hB4,
  parameter logic [7:0] OFF_SC   = 8'h74
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       reg_en_i,
  input  logic       page_hit_i,
  input  logic [7:0] off_i,
  input  logic [7:0] data_i,
  output logic [7:0] mode_o
);
  import wm_pkg::*;

  localparam logic [5:0] SC_HI = OFF_SC[7:2];

  logic [7:0] mode_q, mode_d;
  logic       upd;

  assign upd = wr_i && reg_en_i && page_hit_i;

  always_comb begin
    mode_d = mode_q;
    if (upd) begin
      if (off_i == OFF_MODE)        mode_d = data_i;
      else if (off_i == OFF_FLAG)   mode_d = apply_code(mode_q, data_i[7:6]);
      else if (off_i[7:2] == SC_HI) mode_d = apply_code(mode_q, off_i[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RST;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/wm_flag_enc.sv
module wm_flag_enc (
  input  logic [7:0] mode_i,
  output logic [1:0] code_o
);
  import wm_pkg::*;

  always_comb begin
    unique case (region_of(mode_i))
      RG_HI8:  code_o = 2'b00;
      RG_LO4:  code_o = 2'b01;
      RG_SCR:  code_o = 2'b10;
      default: code_o = 2'b11;
    endcase
  end
endmodule

// File: rtl/wm_region_dec.sv
module wm_region_dec #(
  parameter int         ADDR_W = 16,
  parameter logic [3:0] IO_NIB = 4'hD
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  input  logic              io_mapped_i,
  input  logic [7:0]        mode_i,
  output logic              mirror_o
);
  import wm_pkg::*;

  localparam int TOP = ADDR_W - 1;

  region_e sel;
  logic    hit, z_hit, io_hit, owned;

  assign sel = region_of(mode_i);

  always_comb begin
    unique case (sel)
      RG_HI8:  hit = (addr_i[TOP -: 2] == 2'b10);
      RG_LO0:  hit = (addr_i[TOP -: 2] == 2'b00);
      RG_LO4:  hit = (addr_i[TOP -: 2] == 2'b01);
      RG_TOP:  hit = (addr_i[TOP -: 2] == 2'b11);
      RG_SCR:  hit = (addr_i[TOP -: 6] == 6'b000001);
      RG_NONE: hit = 1'b0;
      default: hit = 1'b1;
    endcase
  end

  assign z_hit  = !mode_i[0] && (sel != RG_NONE) && (addr_i[TOP:9] == '0);
  assign io_hit = io_mapped_i && (addr_i[TOP -: 4] == IO_NIB);
  assign owned  = (bank_i == mode_i[1]) || (sel == RG_ALL);

  assign mirror_o = wr_i && (io_hit || (owned && (hit || z_hit)));
endmodule

// File: rtl/wm_mirror_policy.sv
module wm_mirror_policy #(
  parameter int         ADDR_W   = 16,
  parameter logic [7:0] REG_PAGE = 8'hD0,
  parameter logic [7:0] MODE_RST = 8'hC1,
  parameter logic [7:0] OFF_MODE = 8'hB3,
  parameter logic [7:0] OFF_FLAG = 8'hB4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              bank_i,
  input  logic              io_mapped_i,
  input  logic              reg_en_i,
  output logic              mirror_o,
  output logic [7:0]        rdata_o
);
  localparam logic [3:0] IO_NIB = REG_PAGE[7:4];

  logic       page_hit;
  logic [7:0] off;
  logic [7:0] mode_q;
  logic [1:0] flag_code;

  assign page_hit = (addr_i[ADDR_W-1 -: 8] == REG_PAGE);
  assign off      = addr_i[7:0];

  wm_mode_reg #(
    .MODE_RST(MODE_RST), .OFF_MODE(OFF_MODE), .OFF_FLAG(OFF_FLAG), .OFF_SC(8'h74)
  ) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .reg_en_i(reg_en_i),
    .page_hit_i(page_hit), .off_i(off), .data_i(data_i), .mode_o(mode_q)
  );

  wm_flag_enc u_flag (.mode_i(mode_q), .code_o(flag_code));

  wm_region_dec #(.ADDR_W(ADDR_W), .IO_NIB(IO_NIB)) u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .bank_i(bank_i), .io_mapped_i(io_mapped_i),
    .mode_i(mode_q), .mirror_o(mirror_o)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (page_hit && off == OFF_MODE)      rdata_o = mode_q;
    else if (page_hit && off == OFF_FLAG) rdata_o = {flag_code, 6'b0};
  end
endmodule

// File: rtl/wm_mirror_policy_chk.sv
module wm_mirror_policy_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic [15:0] addr_i,
  input logic [7:0]  data_i,
  input logic        bank_i,
  input logic        io_mapped_i,
  input logic        reg_en_i,
  input logic        mirror_o,
  input logic [7:0]  mode_q,
  input logic [1:0]  flag_code
);
  logic io_wr;
  assign io_wr = wr_i && io_mapped_i && (addr_i[15:12] == 4'hD);

  // R1
  idle_no_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> !mirror_o);

  // R8
  io_always_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr |-> mirror_o);

  // R6
  foreign_bank_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !io_wr && (bank_i != mode_q[1]) && ({mode_q[7:6], mode_q[2]} != 3'b110))
    |-> !mirror_o);

  // R9
  locked_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !reg_en_i) |=> $stable(mode_q));

  // R10
  shortcut_lo4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_en_i && addr_i == 16'hD075) |=> (mode_q[7:6] == 2'b01 && !mode_q[2]));

  // R11
  flag_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_en_i && addr_i == 16'hD0B4) |=> (flag_code == $past(data_i[7:6])));
endmodule

bind wm_mirror_policy wm_mirror_policy_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
  .bank_i(bank_i), .io_mapped_i(io_mapped_i), .reg_en_i(reg_en_i),
  .mirror_o(mirror_o), .mode_q(mode_q), .flag_code(flag_code)
);

// File: tb/tb_wm_mirror_policy.sv
module tb_wm_mirror_policy;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        bank_i = 1'b0;
  logic        io_mapped_i = 1'b0;
  logic        reg_en_i = 1'b0;
  logic        mirror_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_rd;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wm_mirror_policy dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .bank_i(bank_i), .io_mapped_i(io_mapped_i), .reg_en_i(reg_en_i),
    .mirror_o(mirror_o), .rdata_o(rdata_o)
  );

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d, input logic b,
                       input logic io, input logic en, input logic exp, input string tag);
    item_t it;
    @(posedge clk_i); #1;
    wr_i = 1'b1; addr_i = a; data_i = d; bank_i = b; io_mapped_i = io; reg_en_i = en;
    it.is_rd = 1'b0; it.exp = {7'b0, exp}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_idle(input logic [15:0] a, input string tag);
    item_t it;
    @(posedge clk_i); #1;
    wr_i = 1'b0; addr_i = a; io_mapped_i = 1'b1; reg_en_i = 1'b1;
    it.is_rd = 1'b0; it.exp = 8'h00; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk_i); #1;
    wr_i = 1'b0; addr_i = a; reg_en_i = 1'b0; io_mapped_i = 1'b0;
    it.is_rd = 1'b1; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = it.is_rd ? rdata_o : {7'b0, mirror_o};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    do_rd(16'hD0B3, 8'hC1, "R2 mode reset");
    do_rd(16'hD0B4, 8'hC0, "R2 flag reset");
    do_wr(16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R5 all bank0");
    do_wr(16'h1234, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R5 all bank1");
    do_idle(16'hD020, "R1 idle no mirror");

    do_wr(16'hD0B3, 8'h05, 1'b0, 1'b0, 1'b0, 1'b1, "R9 locked write");
    do_rd(16'hD0B3, 8'hC1, "R9 locked unchanged");
    do_wr(16'hD0B3, 8'h05, 1'b0, 1'b0, 1'b1, 1'b1, "R1 old mode used");
    do_rd(16'hD0B3, 8'h05, "R9 mode loaded");
    do_rd(16'hD0B4, 8'hC0, "R11 flag other");
    do_wr(16'h2000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R3 low region in");
    do_wr(16'h5000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R3 low region out");
    do_wr(16'h2000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6 foreign bank");
    do_wr(16'h0100, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R3 zp in low region");

    do_wr(16'hD0B3, 8'h44, 1'b0, 1'b0, 1'b1, 1'b0, "R3 reg write outside");
    do_wr(16'hC100, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R3 top region");
    do_wr(16'h0100, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R7 zp forced");
    do_wr(16'h0200, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R7 zp edge");
    do_wr(16'h0100, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6 zp foreign bank");
    do_wr(16'hD020, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R8 io override");
    do_wr(16'h8000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R3 top region out");

    do_wr(16'hD0B3, 8'h47, 1'b0, 1'b0, 1'b1, 1'b1, "R3 reg write in top");
    do_wr(16'hE000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R6 bank1 owner");
    do_wr(16'hE000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 bank0 dropped");

    do_wr(16'hD0B3, 8'hC6, 1'b0, 1'b0, 1'b1, 1'b0, "R6 reg write foreign");
    do_wr(16'h3000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R5 per bank owner");
    do_wr(16'h3000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R5 per bank other");
    do_wr(16'h0010, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 zp other bank");

    do_wr(16'hD075, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R10 shortcut 75");
    do_rd(16'hD0B3, 8'h42, "R10 mode after 75");
    do_rd(16'hD0B4, 8'h40, "R11 flag 01");
    do_wr(16'h4100, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R3 mid region");
    do_wr(16'h4100, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 mid other bank");

    do_wr(16'hD074, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, "R10 locked shortcut");
    do_rd(16'hD0B3, 8'h42, "R10 shortcut ignored");

    do_wr(16'hD076, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R10 shortcut 76");
    do_rd(16'hD0B4, 8'h80, "R11 flag 10");
    do_wr(16'h0500, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R4 screen in");
    do_wr(16'h0800, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R4 screen out");

    do_wr(16'hD0B4, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R11 flag write");
    do_rd(16'hD0B3, 8'h02, "R11 mode from flag");
    do_wr(16'h9000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R3 high region");

    do_wr(16'hD0B3, 8'h84, 1'b1, 1'b0, 1'b1, 1'b0, "R4 reg write");
    do_wr(16'h0100, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 full opt zp");
    do_wr(16'h0500, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 full opt screen");
    do_wr(16'hD000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R8 io in full opt");
    do_rd(16'hD0B4, 8'hC0, "R11 flag none");

    do_wr(16'hD077, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R10 shortcut 77");
    do_rd(16'hD0B3, 8'hC0, "R10 mode after 77");
    do_wr(16'h7000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R5 all after 77");

    @(posedge clk_i); #1 wr_i = 1'b0;
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule